// File: doc/BRIEF.md
# Clock Generator Control Register Interlock

This block holds the software-visible control state of a clock generator: a bit that turns the PLL on, a bit that asks for the VCO clock instead of the crystal clock as the base clock, a multiplier field and a loop-range field. Software writes all four in one write cycle. The block then applies only the combinations that are safe, so that the clock switcher never gets a request for the VCO clock while the PLL is stopped.

Three outputs carry the settings that take effect. The PLL-on output drives the analog PLL. The VCO-select output goes to the glitch-free clock switcher. The multiplier output goes to the feedback divider. The read outputs return the stored bits, so software can read back after a write and see whether a bit change was refused.

Top module: `clk_gen_ctrl`

## Requirements
- R1: After reset, the stored PLL-on bit is 0, the stored select bit is 0 (crystal), the multiplier reads MULT_RST (default 1) and the loop range reads RANGE_RST (default 0x40, nonzero). All effective outputs follow from these values.
- R2: The effective multiplier is the stored multiplier, except that a stored value of 0 gives an effective multiplier of 1.
- R3: While the stored loop range is 0, the effective PLL-on output and the effective VCO-select output are both 0, whatever the stored bits hold.
- R4: A write that asks the select bit to go from 0 to 1 while the stored PLL-on bit is 0 is refused. The select bit stays 0.
- R5: A write that asks the PLL-on bit to go from 1 to 0 while the stored select bit is 1 is refused. The PLL-on bit stays 1.
- R6: A write that asks both the PLL-on bit and the select bit to change is refused for both bits. The multiplier and loop-range fields of that same write are still stored.
- R7: A write that changes only one of the two bits, where R4 and R5 allow it, takes effect at the clock edge that samples the write. Every write stores the multiplier and loop-range fields.
- R8: Effective PLL-on is 1 exactly when the stored PLL-on bit is 1 and the loop range is nonzero. Effective VCO-select is 1 exactly when the stored select bit is 1, the stored PLL-on bit is 1 and the loop range is nonzero.
- R9: While the write enable is 0, no stored value changes, whatever the write data inputs hold.
- R10: The stored select bit is never 1 while the stored PLL-on bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| wrPllOn | input | 1 | Requested PLL-on bit |
| wrSelVco | input | 1 | Requested select bit (1 = VCO clock, 0 = crystal clock) |
| wrMult | input | MULT_W | Requested multiplier field |
| wrRange | input | RANGE_W | Requested loop-range field |
| rdPllOn | output | 1 | Stored PLL-on bit |
| rdSelVco | output | 1 | Stored select bit |
| rdMult | output | MULT_W | Stored multiplier field |
| rdRange | output | RANGE_W | Stored loop-range field |
| pllOnEff | output | 1 | Effective PLL enable sent to the PLL |
| selVcoEff | output | 1 | Effective VCO select sent to the clock switcher |
| multEff | output | MULT_W | Effective multiplier sent to the feedback divider |

## Verification
The assertions check the invariants on every cycle: the select bit never stands without the PLL-on bit, the two bits never load together, the bits hold when no write is made, a stored select bit keeps the PLL on through the next edge, and a zero loop range gates both effective outputs. Only the bench's scenarios can show that a refused write still stores its multiplier and loop-range fields. The same holds for a legal single-bit change taking effect at the expected edge, for the zero-multiplier substitution producing exactly 1, and for the exact values after reset.

// File: rtl/clk_gen_ctrl_pkg.sv
package clk_gen_ctrl_pkg;

  // Strobes from the write-rule control to the register datapath
  typedef struct packed {
    logic loadFields;  // store multiplier and loop range
    logic loadPll;     // update the PLL-on bit
    logic pllVal;
    logic loadSel;     // update the select bit
    logic selVal;
  } ctrlStrobes_t;

endpackage

// File: rtl/clk_gen_ctrl_rules.sv
module clk_gen_ctrl_rules
  import clk_gen_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrPllOn,
  input  logic         wrSelVco,
  input  logic         pllQ,
  input  logic         selQ,
  output ctrlStrobes_t strb
);

  logic pllChange;
  logic selChange;
  logic pllOffBlocked;
  logic selOnBlocked;

  assign pllChange     = wrPllOn != pllQ;
  assign selChange     = wrSelVco != selQ;
  // Stopping the PLL under a selected VCO clock is refused
  assign pllOffBlocked = !wrPllOn && selQ;
  // Picking the VCO clock while the PLL is stopped is refused
  assign selOnBlocked  = wrSelVco && !pllQ;

  always_comb begin
    strb            = '0;
    strb.pllVal     = wrPllOn;
    strb.selVal     = wrSelVco;
    if (wrEn) begin
      strb.loadFields = 1'b1;
      if (pllChange && selChange) begin
        // Both bits asked to move at once: keep both
        strb.loadPll = 1'b0;
        strb.loadSel = 1'b0;
      end else if (pllChange) begin
        strb.loadPll = !pllOffBlocked;
      end else if (selChange) begin
        strb.loadSel = !selOnBlocked;
      end
    end
  end

  AST_NO_DUAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadPll && strb.loadSel)); // R6

  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPll || strb.loadSel) |-> wrEn); // R9

endmodule

// File: rtl/clk_gen_ctrl_regs.sv
module clk_gen_ctrl_regs
  import clk_gen_ctrl_pkg::*;
#(
  parameter int MULT_W    = 12,
  parameter int RANGE_W   = 8,
  parameter int MULT_RST  = 1,
  parameter int RANGE_RST = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [MULT_W-1:0]  wrMult,
  input  logic [RANGE_W-1:0] wrRange,
  output logic               pllQ,
  output logic               selQ,
  output logic [MULT_W-1:0]  multQ,
  output logic [RANGE_W-1:0] rangeQ,
  output logic               pllOnEff,
  output logic               selVcoEff,
  output logic [MULT_W-1:0]  multEff
);

  localparam logic [MULT_W-1:0]  MULT_ONE    = MULT_W'(1);
  localparam logic [MULT_W-1:0]  MULT_INIT   = MULT_W'(MULT_RST);
  localparam logic [RANGE_W-1:0] RANGE_INIT  = RANGE_W'(RANGE_RST);

  logic rangeLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllQ   <= 1'b0;
      selQ   <= 1'b0;
      multQ  <= MULT_INIT;
      rangeQ <= RANGE_INIT;
    end else begin
      if (strb.loadPll)    pllQ   <= strb.pllVal;
      if (strb.loadSel)    selQ   <= strb.selVal;
      if (strb.loadFields) begin
        multQ  <= wrMult;
        rangeQ <= wrRange;
      end
    end
  end

  assign rangeLive = |rangeQ;
  assign pllOnEff  = pllQ && rangeLive;
  assign selVcoEff = selQ && pllOnEff;
  assign multEff   = (multQ == '0) ? MULT_ONE : multQ;

  AST_SEL_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rstN)
    selQ |-> pllQ); // R10

  AST_PLL_HELD_UNDER_VCO: assert property (@(posedge clk) disable iff (!rstN)
    selQ |=> pllQ); // R5

  AST_SEL_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pllQ |=> !selQ); // R4

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadFields |=> ($stable(pllQ) && $stable(selQ) && $stable(multQ) && $stable(rangeQ))); // R9

  AST_ZERO_RANGE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rangeQ == '0) |-> (!pllOnEff && !selVcoEff)); // R3

  AST_EFF_SEL_IMPLIES_PLL: assert property (@(posedge clk) disable iff (!rstN)
    selVcoEff |-> pllOnEff); // R8

  AST_MULT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    multEff != '0); // R2

endmodule

// File: rtl/clk_gen_ctrl.sv
module clk_gen_ctrl
  import clk_gen_ctrl_pkg::*;
#(
  parameter int MULT_W    = 12,
  parameter int RANGE_W   = 8,
  parameter int MULT_RST  = 1,
  parameter int RANGE_RST = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrPllOn,
  input  logic               wrSelVco,
  input  logic [MULT_W-1:0]  wrMult,
  input  logic [RANGE_W-1:0] wrRange,
  output logic               rdPllOn,
  output logic               rdSelVco,
  output logic [MULT_W-1:0]  rdMult,
  output logic [RANGE_W-1:0] rdRange,
  output logic               pllOnEff,
  output logic               selVcoEff,
  output logic [MULT_W-1:0]  multEff
);

  ctrlStrobes_t strb;
  logic         pllQ;
  logic         selQ;

  clk_gen_ctrl_rules rules_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrPllOn  (wrPllOn),
    .wrSelVco (wrSelVco),
    .pllQ     (pllQ),
    .selQ     (selQ),
    .strb     (strb)
  );

  clk_gen_ctrl_regs #(
    .MULT_W    (MULT_W),
    .RANGE_W   (RANGE_W),
    .MULT_RST  (MULT_RST),
    .RANGE_RST (RANGE_RST)
  ) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrMult    (wrMult),
    .wrRange   (wrRange),
    .pllQ      (pllQ),
    .selQ      (selQ),
    .multQ     (rdMult),
    .rangeQ    (rdRange),
    .pllOnEff  (pllOnEff),
    .selVcoEff (selVcoEff),
    .multEff   (multEff)
  );

  assign rdPllOn  = pllQ;
  assign rdSelVco = selQ;

endmodule

// File: tb/clk_gen_ctrl_tb_top.sv
module clk_gen_ctrl_tb_top;

  localparam int MW = 12;
  localparam int LW = 8;
  // vector: wrPll, wrSel, wrMult, wrRange, expPll, expSel, expPllEff, expSelEff, expMultEff
  localparam int VW = 1 + 1 + MW + LW + 4 + MW;
  localparam int NVEC = 12;

  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 12'd4, 8'h70, 1'b1, 1'b0, 1'b1, 1'b0, 12'd4},  // R7 pll on
    {1'b1, 1'b1, 12'd4, 8'h70, 1'b1, 1'b1, 1'b1, 1'b1, 12'd4},  // R7 select vco
    {1'b0, 1'b1, 12'd8, 8'h70, 1'b1, 1'b1, 1'b1, 1'b1, 12'd8},  // R5 pll off refused
    {1'b0, 1'b0, 12'd8, 8'h70, 1'b1, 1'b1, 1'b1, 1'b1, 12'd8},  // R6 dual change refused
    {1'b1, 1'b0, 12'd0, 8'h70, 1'b1, 1'b0, 1'b1, 1'b0, 12'd1},  // R2 zero mult, R7 deselect
    {1'b1, 1'b1, 12'd2, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 12'd2},  // R3 zero range
    {1'b1, 1'b1, 12'd2, 8'h45, 1'b1, 1'b1, 1'b1, 1'b1, 12'd2},  // R8 range restored
    {1'b1, 1'b0, 12'd2, 8'h45, 1'b1, 1'b0, 1'b1, 1'b0, 12'd2},  // R7 deselect
    {1'b0, 1'b0, 12'd3, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 12'd3},  // R7 pll off
    {1'b0, 1'b1, 12'd3, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 12'd3},  // R4 select refused
    {1'b1, 1'b1, 12'd5, 8'h46, 1'b0, 1'b0, 1'b0, 1'b0, 12'd5},  // R6 dual change refused
    {1'b0, 1'b0, 12'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 12'd1}   // R2 R3 both zero
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          wrPllOn = 1'b0;
  logic          wrSelVco = 1'b0;
  logic [MW-1:0] wrMult = '0;
  logic [LW-1:0] wrRange = '0;
  logic          rdPllOn, rdSelVco, pllOnEff, selVcoEff;
  logic [MW-1:0] rdMult, multEff;
  logic [LW-1:0] rdRange;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  clk_gen_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPllOn(wrPllOn), .wrSelVco(wrSelVco),
    .wrMult(wrMult), .wrRange(wrRange), .rdPllOn(rdPllOn), .rdSelVco(rdSelVco),
    .rdMult(rdMult), .rdRange(rdRange), .pllOnEff(pllOnEff), .selVcoEff(selVcoEff),
    .multEff(multEff)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a write at a falling edge; the rising edge between stores it;
  // outputs are sampled at the following falling edge.
  task automatic doWrite(input logic p, input logic s, input logic [MW-1:0] m, input logic [LW-1:0] r);
    @(negedge clk);
    wrEn = 1'b1; wrPllOn = p; wrSelVco = s; wrMult = m; wrRange = r;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkReset(input string req);
    check({req, " pll"}, 32'(rdPllOn), 32'd0);
    check({req, " sel"}, 32'(rdSelVco), 32'd0);
    check({req, " mult"}, 32'(rdMult), 32'd1);
    check({req, " range"}, 32'(rdRange), 32'h40);
    check({req, " pllEff"}, 32'(pllOnEff), 32'd1 & 32'd0);
    check({req, " selEff"}, 32'(selVcoEff), 32'd0);
    check({req, " multEff"}, 32'(multEff), 32'd1);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset("R1");

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      doWrite(v[VW-1], v[VW-2], v[VW-3 -: MW], v[VW-3-MW -: LW]);
      check($sformatf("R4/R5/R6/R7 vec%0d pll", i), 32'(rdPllOn), 32'(v[MW+3]));
      check($sformatf("R4/R5/R6/R7 vec%0d sel", i), 32'(rdSelVco), 32'(v[MW+2]));
      check($sformatf("R3/R8 vec%0d pllEff", i), 32'(pllOnEff), 32'(v[MW+1]));
      check($sformatf("R3/R8 vec%0d selEff", i), 32'(selVcoEff), 32'(v[MW]));
      check($sformatf("R2 vec%0d multEff", i), 32'(multEff), 32'(v[MW-1:0]));
      check($sformatf("R6/R7 vec%0d mult field", i), 32'(rdMult), 32'(v[VW-3 -: MW]));
      check($sformatf("R6/R7 vec%0d range field", i), 32'(rdRange), 32'(v[VW-3-MW -: LW]));
    end

    // R9: set a known state, then wiggle data with wrEn low
    doWrite(1'b1, 1'b0, 12'd6, 8'h54);
    doWrite(1'b1, 1'b1, 12'd6, 8'h54);
    @(negedge clk);
    wrPllOn = 1'b0; wrSelVco = 1'b0; wrMult = 12'd9; wrRange = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 hold pll", 32'(rdPllOn), 32'd1);
    check("R9 hold sel", 32'(rdSelVco), 32'd1);
    check("R9 hold mult", 32'(rdMult), 32'd6);
    check("R9 hold range", 32'(rdRange), 32'h54);
    check("R8 selEff live", 32'(selVcoEff), 32'd1);

    // R10: after every refused attempt the select bit needs the PLL bit
    doWrite(1'b0, 1'b1, 12'd6, 8'h54);
    check("R10 sel implies pll", 32'(rdSelVco & ~rdPllOn), 32'd0);

    // R1: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset("R1 mid-run");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule